// File: doc/BRIEF.md
# GPIO Interrupt Sense Unit

This unit is the interrupt-detection slice of a general-purpose I/O controller. Each line has a 2-bit sense field that chooses whether the line reacts to both edges, only rising edges, only falling edges, or to nothing. The fields for all lines are held in two control registers. The lower half of the lines is in the first register and the upper half is in the second. Within each register, the field for the lowest-numbered line sits at the top.

Line values come in already synchronized. Each cycle the unit compares them with the sample from the cycle before. A qualifying transition sets a sticky event bit for its line. Software clears event bits by writing ones to the event register. An event bit drives the single interrupt output only while its mask bit is set.

The unit also holds the direction register. A parameter names lines that can only ever be inputs, and the direction bits of those lines cannot be set. In every line-indexed register, line n appears at bit NL-1-n.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `dir_o` is 0.
- R2: The field of line n is 2 bits wide and starts at bit (NL/2-1-(n mod NL/2))*2. Lines below NL/2 use sense register A (address 3). The other lines use sense register B (address 4).
- R3: Field value 00 sets the line's event bit on a rising transition and on a falling transition.
- R4: Field value 01 sets the event bit only on a rising transition.
- R5: Field value 10 sets the event bit only on a falling transition.
- R6: Field value 11 never sets the event bit.
- R7: In the direction (address 0), event (address 1), mask (address 2) and line-sample (address 5) registers, and in `wdata`/`rdata`, line n maps to bit NL-1-n.
- R8: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: An edge on a line in the same cycle as a clear of that line's event bit leaves the bit set.
- R10: `irq_o` is the OR of (event AND mask). It is registered and follows the event and mask registers from the same clock edge.
- R11: Direction bits of lines marked in `IN_ONLY` ignore writes and read as 0. The remaining direction bits are writable, and `dir_o[n]` gives line n.
- R12: A line that holds its level, including a level already present when reset is released, sets no event.
- R13: `rdata` presents the register selected by `addr` one clock after `addr` is applied. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NL (32) | Synchronized line levels, bit n = line n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select for write and read |
| wdata | input | NL (32) | Write data, line n at bit NL-1-n |
| rdata | output | NL (32) | Registered read data |
| dir_o | output | NL (32) | Direction per line, bit n = line n, 1 = output |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Two functions can land on the same clock edge. One is the software clear of an event bit. The other is a fresh transition on that same line, which sets the bit again. The bench raises the write-1 strobe for a line's event bit at the same negative edge where it toggles that line and a second line. The result is judged by reading the event register afterwards: both bits must be set. The bench also checks that a clear on one line alongside an edge on another keeps the two apart.

// File: rtl/gis_pkg.sv
package gis_pkg;

  localparam int AW = 3;

  localparam logic [AW-1:0] A_DIR  = 3'd0;
  localparam logic [AW-1:0] A_EVT  = 3'd1;
  localparam logic [AW-1:0] A_MSK  = 3'd2;
  localparam logic [AW-1:0] A_SNA  = 3'd3;
  localparam logic [AW-1:0] A_SNB  = 3'd4;
  localparam logic [AW-1:0] A_LINE = 3'd5;

  typedef enum logic [1:0] {
    SENSE_ANY  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_OFF  = 2'b11
  } sense_e;

endpackage

// File: rtl/gis_field_map.sv
// Extracts the per-line sense field from the two packed control registers.
module gis_field_map #(
  parameter int NL = 32
) (
  input  logic [NL-1:0]      sense_a,
  input  logic [NL-1:0]      sense_b,
  output logic [NL-1:0][1:0] mode
);

  localparam int HALF = NL / 2;

  for (genvar n = 0; n < NL; n++) begin : g_line
    localparam int POS = (HALF - 1 - (n % HALF)) * 2;
    if (n < HALF) begin : g_lo
      assign mode[n] = sense_a[POS +: 2];
    end else begin : g_hi
      assign mode[n] = sense_b[POS +: 2];
    end
  end

endmodule

// File: rtl/gis_edge_detect.sv
// Qualifies transitions between consecutive samples by each line's sense mode.
module gis_edge_detect
  import gis_pkg::*;
#(
  parameter int NL = 32
) (
  input  logic [NL-1:0]      now_s,
  input  logic [NL-1:0]      prev_s,
  input  logic [NL-1:0][1:0] mode,
  output logic [NL-1:0]      hit
);

  logic [NL-1:0] rise, fall;

  assign rise = now_s & ~prev_s;
  assign fall = ~now_s & prev_s;

  always_comb begin
    hit = '0;
    for (int i = 0; i < NL; i++) begin
      case (sense_e'(mode[i]))
        SENSE_ANY:  hit[i] = rise[i] | fall[i];
        SENSE_RISE: hit[i] = rise[i];
        SENSE_FALL: hit[i] = fall[i];
        default:    hit[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gis_event_bank.sv
// Sticky event bits with write-1 clear, mask register and registered interrupt.
module gis_event_bank #(
  parameter int NL = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] hit,
  input  logic [NL-1:0] clr,
  input  logic          mask_wr,
  input  logic [NL-1:0] mask_d,
  output logic [NL-1:0] evt_q,
  output logic [NL-1:0] mask_q,
  output logic          irq_q
);

  logic [NL-1:0] evt_n, mask_n;

  // a new edge takes priority over a clear in the same cycle
  assign evt_n  = (evt_q & ~clr) | hit;
  assign mask_n = mask_wr ? mask_d : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      evt_q  <= evt_n;
      mask_q <= mask_n;
      irq_q  <= |(evt_n & mask_n);
    end
  end

endmodule

// File: rtl/gpio_irq_sense.sv
// Interrupt sense unit of a GPIO controller: sense decode, edge capture,
// event/mask/clear and input-only direction filtering.
module gpio_irq_sense
  import gis_pkg::*;
#(
  parameter int            NL      = 32,
  parameter logic [NL-1:0] IN_ONLY = {4'hF, {(NL-4){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] line_in,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] wdata,
  output logic [NL-1:0] rdata,
  output logic [NL-1:0] dir_o,
  output logic          irq_o
);

  logic [NL-1:0]      prev_q, dir_q, sense_a_q, sense_b_q, rdata_q;
  logic [NL-1:0]      wdata_ln;
  logic [NL-1:0]      dir_rv, evt_rv, mask_rv, line_rv;
  logic [NL-1:0]      hit_w, clr_w, evt_w, mask_w;
  logic [NL-1:0][1:0] mode_w;
  logic [NL-1:0]      rd_mux;
  logic               wr_dir, wr_evt, wr_msk, wr_sna, wr_snb;

  // line-order <-> register-order conversion
  for (genvar i = 0; i < NL; i++) begin : g_rev
    assign wdata_ln[i]       = wdata[NL-1-i];
    assign dir_rv[NL-1-i]    = dir_q[i];
    assign evt_rv[NL-1-i]    = evt_w[i];
    assign mask_rv[NL-1-i]   = mask_w[i];
    assign line_rv[NL-1-i]   = prev_q[i];
  end

  assign wr_dir = wr_en && (addr == A_DIR);
  assign wr_evt = wr_en && (addr == A_EVT);
  assign wr_msk = wr_en && (addr == A_MSK);
  assign wr_sna = wr_en && (addr == A_SNA);
  assign wr_snb = wr_en && (addr == A_SNB);

  assign clr_w = wr_evt ? wdata_ln : '0;

  gis_field_map #(.NL(NL)) u_map (
    .sense_a (sense_a_q),
    .sense_b (sense_b_q),
    .mode    (mode_w)
  );

  gis_edge_detect #(.NL(NL)) u_edge (
    .now_s  (line_in),
    .prev_s (prev_q),
    .mode   (mode_w),
    .hit    (hit_w)
  );

  gis_event_bank #(.NL(NL)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit_w),
    .clr     (clr_w),
    .mask_wr (wr_msk),
    .mask_d  (wdata_ln),
    .evt_q   (evt_w),
    .mask_q  (mask_w),
    .irq_q   (irq_o)
  );

  always_comb begin
    case (addr)
      A_DIR:   rd_mux = dir_rv;
      A_EVT:   rd_mux = evt_rv;
      A_MSK:   rd_mux = mask_rv;
      A_SNA:   rd_mux = sense_a_q;
      A_SNB:   rd_mux = sense_b_q;
      A_LINE:  rd_mux = line_rv;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= line_in;   // primes the history so held levels raise nothing
      dir_q     <= '0;
      sense_a_q <= '0;
      sense_b_q <= '0;
      rdata_q   <= '0;
    end else begin
      prev_q  <= line_in;
      rdata_q <= rd_mux;
      if (wr_dir) dir_q     <= wdata_ln & ~IN_ONLY;
      if (wr_sna) sense_a_q <= wdata;
      if (wr_snb) sense_b_q <= wdata;
    end
  end

  assign rdata = rdata_q;
  assign dir_o = dir_q;

endmodule

// File: rtl/gis_chk.sv
// Property checker attached to gpio_irq_sense.
module gis_chk #(
  parameter int            NL      = 32,
  parameter logic [NL-1:0] IN_ONLY = '0
) (
  input logic                clk,
  input logic                rst,
  input logic [NL-1:0]       dir_q,
  input logic [NL-1:0]       evt,
  input logic [NL-1:0]       mask,
  input logic [NL-1:0]       hit,
  input logic [NL-1:0]       clr,
  input logic [NL-1:0][1:0]  mode,
  input logic                irq
);

  AST_DIR_INPUT_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((dir_q & IN_ONLY) == '0));  // R11

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(evt) & ~$past(clr)) & ~evt) == '0));  // R8

  AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(clr) & ~$past(hit) & evt) == '0));  // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(hit) & ~evt) == '0));  // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq == |(evt & mask));  // R10

  for (genvar i = 0; i < NL; i++) begin : g_rsv
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
      (mode[i] == 2'b11) |-> !hit[i]);  // R6
  end

endmodule

bind gpio_irq_sense gis_chk #(.NL(NL), .IN_ONLY(IN_ONLY)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .dir_q (dir_q),
  .evt   (evt_w),
  .mask  (mask_w),
  .hit   (hit_w),
  .clr   (clr_w),
  .mode  (mode_w),
  .irq   (irq_o)
);

// File: tb/gpio_irq_sense_tb_top.sv
module gpio_irq_sense_tb_top;

  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [NL-1:0] line_in;
  logic          wr_en;
  logic [2:0]    addr;
  logic [NL-1:0] wdata;
  logic [NL-1:0] rdata;
  logic [NL-1:0] dir_o;
  logic          irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gpio_irq_sense #(.NL(NL)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .line_in (line_in),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .dir_o   (dir_o),
    .irq_o   (irq_o)
  );

  function automatic logic [31:0] lb(input int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    line_in = v;
    @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reg after reset", d, 32'h0);
    end
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    chk("R1 dir_o after reset", dir_o, 32'h0);
    rd(3'd5, d);
    chk("R7 line sample order", d, 32'hFF00_0000);
    rd(3'd1, d);
    chk("R12 held level no event", d, 32'h0);
    drive(32'h0);
    rd(3'd1, d);
    chk("R3 both-edge fall lines 0-7", d, 32'hFF00_0000);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d);
    chk("R8 clear all", d, 32'h0);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    wr(3'd3, (32'h1 << 26) | (32'h2 << 24));   // line2 rise, line3 fall
    wr(3'd4, 32'h2 << 28);                     // line17 fall
    drive(32'h0002_001E);
    rd(3'd1, d);
    chk("R4/R2 rising set", d, lb(1) | lb(2) | lb(4));
    wr(3'd1, 32'hFFFF_FFFF);
    drive(32'h0);
    rd(3'd1, d);
    chk("R5/R2 falling set", d, lb(1) | lb(3) | lb(4) | lb(17));
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(3'd3, 32'h3 << 18);                     // line6 off
    drive(32'h40);
    rd(3'd1, d);
    chk("R6 reserved rise", d, 32'h0);
    drive(32'h0);
    rd(3'd1, d);
    chk("R6 reserved fall", d, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(3'd3, 32'h0);
    drive(32'h201);
    rd(3'd1, d);
    chk("R3 lines 0 and 9", d, lb(0) | lb(9));
    wr(3'd1, 32'h0);
    rd(3'd1, d);
    chk("R8 zero write keeps", d, lb(0) | lb(9));
    wr(3'd1, lb(0));
    rd(3'd1, d);
    chk("R8 selective clear", d, lb(9));
  endtask

  task automatic t_collision;
    logic [31:0] d;
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd1; wdata = lb(9);
    line_in = line_in ^ 32'h0000_1200;         // toggle lines 9 and 12
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd1, d);
    chk("R9 set beats clear", d, lb(9) | lb(12));
  endtask

  task automatic t_irq;
    logic [31:0] d;
    chk("R10 masked off", {31'h0, irq_o}, 32'h0);
    wr(3'd2, lb(12));
    chk("R10 unmask raises", {31'h0, irq_o}, 32'h1);
    rd(3'd2, d);
    chk("R7 mask readback", d, lb(12));
    wr(3'd1, lb(12));
    chk("R10 clear drops", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d);
    chk("R11 input-only read 0", d, 32'hFFFF_FFF0);
    chk("R11 dir_o line order", dir_o, 32'h0FFF_FFFF);
    wr(3'd0, 32'h0);
    rd(3'd0, d);
    chk("R11 dir cleared", d, 32'h0);
    rd(3'd6, d);
    chk("R13 unused address", d, 32'h0);
  endtask

  initial begin
    rst = 1'b1; line_in = 32'hFF; wr_en = 1'b0; addr = 3'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_modes();
    t_reserved();
    t_clear();
    t_collision();
    t_irq();
    t_dir();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule